// File: doc/BRIEF.md
# ATA DMA Mode Selector

This block picks the fastest DMA transfer mode that a drive and its host controller can both use. It reads the drive's identify words (the validity bits, the Ultra DMA, multiword DMA and single-word DMA mode words, and an older single-word timing value). It also takes the host's capability mask for each class, an 80-wire cable flag, the media type and the mode the caller asks for. The answer is an ATA transfer-mode code. Single-word modes start at 0x10, multiword modes at 0x20 and Ultra modes at 0x40. A code of 0 means no DMA.

A one-cycle `start` pulse samples every input. On the next cycle the block returns the mode and a flag that marks malformed identify data, with a one-cycle `done` pulse. The result stays on the outputs until the next `start`. The block only decides on a mode. It does not program the drive. There is no data stream, so there is no valid/ready handshake and no back-pressure: `start` is always accepted, and `done` is a plain pulse that the caller must catch.

Top module: `dma_mode_sel`

## Requirements
- R1: After reset, `done`, `mode_out` and `id_bad` are 0. A `start` in one cycle gives `done`=1 in the next cycle only. `mode_out` and `id_bad` keep their values until the next `start`, whatever the inputs do in between.
- R2: The classes are tried in this fixed order: Ultra (base 0x40, needs `id_valid[2]`), then multiword (base 0x20, needs `id_valid[1]`), then single-word (base 0x10). A class is skipped when `req_mode` is below its base. The usable mask of a class is its host mask ANDed with the low byte of the drive word. The first class with a nonzero usable mask wins, and the mode is the class base plus the index of the highest set bit.
- R3: When `req_mode` is above 0x42, the Ultra usable mask has any of bits 3 to 6 set, and `cable80` is 0, the Ultra mask is cut down to bits 0 to 2 before selection.
- R4: The single-word class uses the low byte of its mode word when `id_valid[1]` is 1. Otherwise, if `sw_timing` is 1 or 2, it uses the mask (2 << `sw_timing`) - 1 ANDed with the host mask. Any other timing value gives an empty mask.
- R5: The output mode is the smaller of the selected mode and `req_mode`.
- R6: When no class yields a usable mask, the output mode is 0.
- R7: When `is_disk` is 0 and `host_no_pkt_dma` is 1, the output mode is 0. Either flag on its own has no effect.
- R8: `id_bad` is 1 when `id_valid[2]` is 1 and the upper bytes of both the Ultra and multiword words are nonzero. It is also 1 when `id_valid[2]` is 0, `id_valid[1]` is 1, and the upper bytes of both the multiword and single-word words are nonzero. In every other case it is 0, and it never changes the chosen mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Samples the inputs and launches an evaluation |
| id_valid | input | 2 | Identify field-valid bits 2 and 1 |
| udma_word | input | WORD_W | Drive Ultra DMA mode word |
| mwdma_word | input | WORD_W | Drive multiword DMA mode word |
| swdma_word | input | WORD_W | Drive single-word DMA mode word |
| sw_timing | input | WORD_W | Older single-word timing value |
| udma_host | input | MASK_W | Host Ultra mode mask |
| mwdma_host | input | MASK_W | Host multiword mode mask |
| swdma_host | input | MASK_W | Host single-word mode mask |
| cable80 | input | 1 | 80-wire cable detected |
| is_disk | input | 1 | Device is a disk (not a packet device) |
| host_no_pkt_dma | input | 1 | Host forbids DMA for packet devices |
| req_mode | input | 8 | Requested (ceiling) mode code |
| done | output | 1 | One-cycle result strobe |
| mode_out | output | 8 | Selected mode code, 0 for none |
| id_bad | output | 1 | Malformed identify data |

## Verification
The assertions assume that `rst_n` is released synchronously and that every input is steady around the clock edge on which `start` is high. The result checks also assume that any value may arrive between pulses, which is why the hold property compares only the outputs. The bench changes inputs only on falling edges. It raises `start` for exactly one cycle, and it scrambles the inputs between pulses to show that the held result is left alone.

// File: rtl/dma_sel_pkg.sv
package dma_sel_pkg;
  localparam int NCLS     = 3;
  localparam int CLS_UDMA = 0;
  localparam int CLS_MW   = 1;
  localparam int CLS_SW   = 2;

  // ATA transfer-mode encoding: class bases
  localparam logic [7:0] BASE_UDMA = 8'h40;
  localparam logic [7:0] BASE_MW   = 8'h20;
  localparam logic [7:0] BASE_SW   = 8'h10;

  function automatic logic [7:0] class_base(input int k);
    case (k)
      CLS_UDMA: class_base = BASE_UDMA;
      CLS_MW:   class_base = BASE_MW;
      default:  class_base = BASE_SW;
    endcase
  endfunction
endpackage

// File: rtl/dma_mask_build.sv
module dma_mask_build
  import dma_sel_pkg::*;
#(
  parameter int MASK_W = 8,
  parameter int WORD_W = 16
) (
  input  logic [2:1]                         id_valid,
  input  logic [MASK_W-1:0]                  udma_lo,
  input  logic [MASK_W-1:0]                  mw_lo,
  input  logic [MASK_W-1:0]                  sw_lo,
  input  logic [WORD_W-1:0]                  sw_timing,
  input  logic [MASK_W-1:0]                  udma_host,
  input  logic [MASK_W-1:0]                  mwdma_host,
  input  logic [MASK_W-1:0]                  swdma_host,
  input  logic                               cable80,
  input  logic [7:0]                         req_mode,
  output logic [NCLS-1:0][MASK_W-1:0]        raw
);
  localparam logic [MASK_W-1:0] LOW3 = MASK_W'(7);

  logic [MASK_W-1:0] u_m;
  logic              fast_req;
  logic              timing_ok;

  assign fast_req  = req_mode > (BASE_UDMA + 8'd2);
  assign timing_ok = (sw_timing != '0) && (sw_timing <= WORD_W'(2));

  always_comb begin
    u_m = id_valid[2] ? (udma_host & udma_lo) : '0;
    if (fast_req && (|u_m[6:3]) && !cable80)
      u_m = u_m & LOW3;
    raw[CLS_UDMA] = u_m;
    raw[CLS_MW]   = id_valid[1] ? (mwdma_host & mw_lo) : '0;
    if (id_valid[1])
      raw[CLS_SW] = swdma_host & sw_lo;
    else if (timing_ok)
      raw[CLS_SW] = swdma_host & MASK_W'((32'd2 << sw_timing[1:0]) - 32'd1);
    else
      raw[CLS_SW] = '0;
  end
endmodule

// File: rtl/dma_class_pick.sv
module dma_class_pick #(
  parameter int         MASK_W = 8,
  parameter logic [7:0] BASE   = 8'h40
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [7:0]        req_mode,
  output logic              hit,
  output logic [7:0]        mode
);
  logic [7:0] idx;
  logic       any;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int b = 0; b < MASK_W; b++) begin
      if (mask[b]) begin
        idx = 8'(b);
        any = 1'b1;
      end
    end
  end

  assign hit  = any && (req_mode >= BASE);
  assign mode = BASE + idx;
endmodule

// File: rtl/dma_id_check.sv
module dma_id_check #(
  parameter int WORD_W = 16
) (
  input  logic [2:1]          id_valid,
  input  logic [WORD_W-1:WORD_W/2] udma_hi,
  input  logic [WORD_W-1:WORD_W/2] mw_hi,
  input  logic [WORD_W-1:WORD_W/2] sw_hi,
  output logic                bad
);
  always_comb begin
    if (id_valid[2])
      bad = (|udma_hi) && (|mw_hi);
    else if (id_valid[1])
      bad = (|mw_hi) && (|sw_hi);
    else
      bad = 1'b0;
  end
endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
  import dma_sel_pkg::*;
#(
  parameter int MASK_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:1]        id_valid,
  input  logic [WORD_W-1:0] udma_word,
  input  logic [WORD_W-1:0] mwdma_word,
  input  logic [WORD_W-1:0] swdma_word,
  input  logic [WORD_W-1:0] sw_timing,
  input  logic [MASK_W-1:0] udma_host,
  input  logic [MASK_W-1:0] mwdma_host,
  input  logic [MASK_W-1:0] swdma_host,
  input  logic              cable80,
  input  logic              is_disk,
  input  logic              host_no_pkt_dma,
  input  logic [7:0]        req_mode,
  output logic              done,
  output logic [7:0]        mode_out,
  output logic              id_bad
);
  logic [NCLS-1:0][MASK_W-1:0] raw;
  logic [NCLS-1:0]             hit;
  logic [7:0]                  cmode [NCLS];
  logic [7:0]                  sel;
  logic                        found;
  logic [7:0]                  final_mode;
  logic                        bad_c;

  dma_mask_build #(.MASK_W(MASK_W), .WORD_W(WORD_W)) u_build (
    .id_valid   (id_valid),
    .udma_lo    (udma_word[MASK_W-1:0]),
    .mw_lo      (mwdma_word[MASK_W-1:0]),
    .sw_lo      (swdma_word[MASK_W-1:0]),
    .sw_timing  (sw_timing),
    .udma_host  (udma_host),
    .mwdma_host (mwdma_host),
    .swdma_host (swdma_host),
    .cable80    (cable80),
    .req_mode   (req_mode),
    .raw        (raw)
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    dma_class_pick #(.MASK_W(MASK_W), .BASE(class_base(k))) u_pick (
      .mask     (raw[k]),
      .req_mode (req_mode),
      .hit      (hit[k]),
      .mode     (cmode[k])
    );
  end

  dma_id_check #(.WORD_W(WORD_W)) u_idchk (
    .id_valid (id_valid),
    .udma_hi  (udma_word[WORD_W-1:WORD_W/2]),
    .mw_hi    (mwdma_word[WORD_W-1:WORD_W/2]),
    .sw_hi    (swdma_word[WORD_W-1:WORD_W/2]),
    .bad      (bad_c)
  );

  // fixed priority: lowest class index first
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < NCLS; k++) begin
      if (!found && hit[k]) begin
        sel   = cmode[k];
        found = 1'b1;
      end
    end
    if (!is_disk && host_no_pkt_dma)
      final_mode = '0;
    else if (sel < req_mode)
      final_mode = sel;
    else
      final_mode = req_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      mode_out <= '0;
      id_bad   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        mode_out <= final_mode;
        id_bad   <= bad_c;
      end
    end
  end
endmodule

// File: rtl/dma_mode_sel_chk.sv
module dma_mode_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       is_disk,
  input logic       host_no_pkt_dma,
  input logic [7:0] req_mode,
  input logic       done,
  input logic [7:0] mode_out,
  input logic       id_bad
);
  a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r1_done_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r1_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(mode_out) && $stable(id_bad)));
  a_r5_capped: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mode_out <= $past(req_mode)));
  a_r7_packet_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_disk && host_no_pkt_dma) |=> (mode_out == 8'h00));
  a_r2_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mode_out == 8'h00 || mode_out >= 8'h10));
endmodule

bind dma_mode_sel dma_mode_sel_chk u_chk (.*);

// File: tb/tb_dma_mode_sel.sv
module tb_dma_mode_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:1]  id_valid;
  logic [15:0] udma_word, mwdma_word, swdma_word, sw_timing;
  logic [7:0]  udma_host, mwdma_host, swdma_host;
  logic        cable80, is_disk, host_no_pkt_dma;
  logic [7:0]  req_mode;
  logic        done;
  logic [7:0]  mode_out;
  logic        id_bad;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mode_sel dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    id_valid = 2'b00;
    udma_word = '0; mwdma_word = '0; swdma_word = '0; sw_timing = '0;
    udma_host = 8'hFF; mwdma_host = 8'hFF; swdma_host = 8'hFF;
    cable80 = 1'b1; is_disk = 1'b1; host_no_pkt_dma = 1'b0;
    req_mode = 8'h46;
  endtask

  // pulse start, then check the registered result one cycle later
  task automatic run(input string tag, input logic [7:0] exp_mode, input logic exp_bad);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " done"}, {7'd0, done}, 8'd1);
    chk({tag, " mode"}, mode_out, exp_mode);
    chk({tag, " bad"}, {7'd0, id_bad}, {7'd0, exp_bad});
    defaults();
  endtask

  task automatic t_reset();
    chk("R1 reset done", {7'd0, done}, 8'd0);
    chk("R1 reset mode", mode_out, 8'd0);
    chk("R1 reset bad", {7'd0, id_bad}, 8'd0);
  endtask

  task automatic t_hold();
    id_valid = 2'b10; udma_word = 16'h003F;
    run("R1 launch", 8'h45, 1'b0);
    @(negedge clk);
    chk("R1 done drops", {7'd0, done}, 8'd0);
    id_valid = 2'b11; udma_word = 16'h0401; mwdma_word = 16'h0401; req_mode = 8'h10;
    @(negedge clk); @(negedge clk);
    chk("R1 held mode", mode_out, 8'h45);
    chk("R1 held bad", {7'd0, id_bad}, 8'd0);
    defaults();
  endtask

  task automatic t_order();
    id_valid = 2'b11; udma_word = 16'h003F; mwdma_word = 16'h0007;
    run("R2 ultra wins", 8'h45, 1'b0);
    id_valid = 2'b10; udma_word = 16'h003F; udma_host = 8'h07;
    run("R2 host mask", 8'h42, 1'b0);
    id_valid = 2'b01; udma_word = 16'h003F; mwdma_word = 16'h0005;
    run("R2 ultra invalid", 8'h22, 1'b0);
    id_valid = 2'b11; udma_word = 16'h003F; mwdma_word = 16'h0007; req_mode = 8'h24;
    run("R2 ultra skipped", 8'h22, 1'b0);
  endtask

  task automatic t_cable();
    id_valid = 2'b10; udma_word = 16'h003F; cable80 = 1'b0;
    run("R3 downgrade", 8'h42, 1'b0);
    id_valid = 2'b11; udma_word = 16'h0008; mwdma_word = 16'h0003; cable80 = 1'b0;
    run("R3 emptied", 8'h21, 1'b0);
    id_valid = 2'b10; udma_word = 16'h0008; cable80 = 1'b0; req_mode = 8'h42;
    run("R3 low req", 8'h42, 1'b0);
  endtask

  task automatic t_legacy();
    sw_timing = 16'd2;
    run("R4 timing2", 8'h12, 1'b0);
    sw_timing = 16'd1; swdma_host = 8'h01;
    run("R4 timing1", 8'h10, 1'b0);
    sw_timing = 16'd3;
    run("R4 timing3", 8'h00, 1'b0);
    sw_timing = 16'd0;
    run("R4 timing0", 8'h00, 1'b0);
    id_valid = 2'b01; swdma_word = 16'h0003; sw_timing = 16'd2;
    run("R4 word used", 8'h11, 1'b0);
  endtask

  task automatic t_cap();
    id_valid = 2'b10; udma_word = 16'h007F; req_mode = 8'h44;
    run("R5 cap", 8'h44, 1'b0);
    id_valid = 2'b01; mwdma_word = 16'h0007; req_mode = 8'h21;
    run("R5 cap mw", 8'h21, 1'b0);
    id_valid = 2'b11; udma_word = 16'h003F; mwdma_word = 16'h0007; swdma_word = 16'h0007;
    req_mode = 8'h0C;
    run("R6 below all", 8'h00, 1'b0);
    id_valid = 2'b11;
    run("R6 empty masks", 8'h00, 1'b0);
  endtask

  task automatic t_packet();
    id_valid = 2'b10; udma_word = 16'h003F; is_disk = 1'b0; host_no_pkt_dma = 1'b1;
    run("R7 blocked", 8'h00, 1'b0);
    id_valid = 2'b10; udma_word = 16'h003F; is_disk = 1'b0;
    run("R7 pkt allowed", 8'h45, 1'b0);
    id_valid = 2'b10; udma_word = 16'h003F; host_no_pkt_dma = 1'b1;
    run("R7 disk", 8'h45, 1'b0);
  endtask

  task automatic t_malformed();
    id_valid = 2'b10; udma_word = 16'h043F; mwdma_word = 16'h0407;
    run("R8 ultra pair", 8'h45, 1'b1);
    id_valid = 2'b01; mwdma_word = 16'h0407; swdma_word = 16'h0107;
    run("R8 mw pair", 8'h22, 1'b1);
    id_valid = 2'b11; udma_word = 16'h003F; mwdma_word = 16'h0407; swdma_word = 16'h0107;
    run("R8 ultra rule governs", 8'h45, 1'b0);
    udma_word = 16'h0100; mwdma_word = 16'h0100; swdma_word = 16'h0100;
    run("R8 none valid", 8'h00, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_order();
    t_cable();
    t_legacy();
    t_cap();
    t_packet();
    t_malformed();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule